// File: doc/BRIEF.md
# Amplifier Power-State and Fault Manager

This block decides which power state an amplifier output stage is in. It also turns a set of digital fault flags into a fault report. A register field requests one of four states: deep sleep, sleep, high impedance or play. The block registers that request as the effective state, unless an error is present. While an error is present, the output stage is held in high impedance. The requested state returns on its own once the error has gone.

Seven fault flags come in from sensing logic outside the block: over-current, supply under-voltage, supply over-voltage, clock fault, over-temperature shutdown, over-temperature warning and DC offset. Configuration bits decide, for each flag, whether it follows its input or is held once set. The warning can be masked. A write-one pulse clears the held flags. Any reported flag drives the active-low fault output. An open-drain pad outside the block turns a 0 into a pull-down. The temperature warning is reported but does not force high impedance.

Top module: `pwr_fault_mgr`

## Requirements
- R1: With no error flag set, `state_eff` equals the value `state_req` had one cycle earlier. The encoding is 00 deep sleep, 01 sleep, 10 high impedance and 11 play, and a change from 00 straight to 11 is taken in one step.
- R2: During reset, `state_eff` is 00, `flt_flags` is all zero and `fault_n` is 1.
- R3: The error flags are bits 0 (over-current), 1 (under-voltage), 2 (over-voltage), 3 (clock), 4 (over-temperature shutdown) and 6 (DC offset). If any of them is set in `flt_flags`, `state_eff` is 10 on the next cycle, whatever `state_req` holds. Once they are all clear, the requested state returns one cycle later.
- R4: Flag bits 0, 1 and 2 always equal their `flt_in` bit from one cycle earlier.
- R5: Flag bit 6 (DC offset) sets from its input and then stays set until `fault_clr` is pulsed.
- R6: Flag bit 3 is held when `latch_clk_en` is 1 and follows its input otherwise. Flag bit 5 (temperature warning) behaves the same way under `latch_otw_en`.
- R7: Flag bit 4 is held only when `latch_otsd_en` is 1 and `otsd_autorec_en` is 0. Otherwise it follows its input.
- R8: While `otw_mask` is 1, flag bit 5 reads 0 on the next cycle and does not pull `fault_n` low.
- R9: Flag bit 5 on its own pulls `fault_n` low but leaves `state_eff` at the requested state.
- R10: `fault_n` is 0 exactly when some bit of `flt_flags` is set, so it changes in the same cycle as the flags.
- R11: A `fault_clr` pulse clears every held flag on the next cycle. If a flag's input is still high in the cycle of the pulse, that flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| state_req | input | 2 | Requested power state |
| flt_in | input | 7 | Fault flags from the sensing logic (bit positions as in R3) |
| latch_clk_en | input | 1 | Hold clock faults once set |
| latch_otsd_en | input | 1 | Hold over-temperature shutdowns once set |
| latch_otw_en | input | 1 | Hold temperature warnings once set |
| otw_mask | input | 1 | Suppress the temperature warning |
| otsd_autorec_en | input | 1 | Let an over-temperature shutdown clear when its cause goes away |
| fault_clr | input | 1 | Write-one pulse that clears held flags |
| state_eff | output | 2 | Effective power state |
| flt_flags | output | 7 | Reported fault flags |
| fault_n | output | 1 | Active-low fault indication for an open-drain pad |

## Verification
The assertions assume that `flt_in`, `fault_clr` and the configuration bits are synchronous to `clk` and hold steady for a whole cycle. They also assume that `fault_clr` is a pulse one cycle long. The bench changes inputs only on falling edges, and it raises `fault_clr` for exactly one cycle. It changes the configuration only while all flags are zero. This keeps every sweep step starting from a known state with no held flags.

// File: rtl/pfm_pkg.sv
// Shared constants and types for the power-state and fault manager.
// Assumes the fault bit positions below are fixed by the surrounding logic.
package pfm_pkg;
    localparam int NFLT   = 7;
    localparam int ST_W   = 2;
    localparam int F_OC   = 0;
    localparam int F_UV   = 1;
    localparam int F_OV   = 2;
    localparam int F_CLK  = 3;
    localparam int F_OTSD = 4;
    localparam int F_OTW  = 5;
    localparam int F_DC   = 6;
    // Errors force high impedance; the warning bit is excluded.
    localparam logic [NFLT-1:0] ERR_BITS = ~(NFLT'(1) << F_OTW);

    typedef enum logic [ST_W-1:0] {
        ST_DEEP  = 2'b00,
        ST_SLEEP = 2'b01,
        ST_HIZ   = 2'b10,
        ST_PLAY  = 2'b11
    } pstate_e;
endpackage

// File: rtl/pfm_fault_cell.sv
// One fault flag: follows its input, or holds it until a clear pulse.
// A mask forces the flag to zero. When a clear and an input arrive together, the input wins.
module pfm_fault_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic latch_en,
    input  logic clr,
    input  logic mask,
    output logic q
);
    // Update the flag from the input, the hold mode, the clear and the mask.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= 1'b0;
        else if (mask)     q <= 1'b0;
        else if (latch_en) q <= (q & ~clr) | raw;
        else               q <= raw;
    end
endmodule

// File: rtl/pfm_fault_bank.sv
// One fault cell per flag bit, each with its own hold and mask control.
// Assumes the controls are already decoded per bit by the parent.
module pfm_fault_bank
    import pfm_pkg::*;
#(
    parameter int N = NFLT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] latch_en,
    input  logic [N-1:0] mask,
    input  logic         clr,
    output logic [N-1:0] flags
);
    for (genvar g = 0; g < N; g++) begin : g_cell
        pfm_fault_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw      (raw[g]),
            .latch_en (latch_en[g]),
            .clr      (clr),
            .mask     (mask[g]),
            .q        (flags[g])
        );
    end
endmodule

// File: rtl/pfm_state_ctrl.sv
// Registers the effective power state. An active error overrides the request
// with high impedance. Assumes err_any comes from registered flags.
module pfm_state_ctrl
    import pfm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] req,
    input  logic            err_any,
    output logic [ST_W-1:0] state
);
    pstate_e st_q;

    // Take the request, or high impedance while an error is present.
    always_ff @(posedge clk) begin
        if (!rst_n)       st_q <= ST_DEEP;
        else if (err_any) st_q <= ST_HIZ;
        else              st_q <= pstate_e'(req);
    end

    assign state = st_q;
endmodule

// File: rtl/pwr_fault_mgr.sv
// Power-state and fault manager top. It decodes the hold and mask controls per
// fault bit, keeps the flags, drives the active-low fault output and sequences
// the power state. Assumes all inputs are synchronous to clk.
module pwr_fault_mgr
    import pfm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] state_req,
    input  logic [NFLT-1:0] flt_in,
    input  logic            latch_clk_en,
    input  logic            latch_otsd_en,
    input  logic            latch_otw_en,
    input  logic            otw_mask,
    input  logic            otsd_autorec_en,
    input  logic            fault_clr,
    output logic [ST_W-1:0] state_eff,
    output logic [NFLT-1:0] flt_flags,
    output logic            fault_n
);
    logic [NFLT-1:0] hold_v;
    logic [NFLT-1:0] mask_v;
    logic            err_any;

    // Decode the per-bit hold mode from the configuration bits.
    always_comb begin
        hold_v         = '0;
        hold_v[F_CLK]  = latch_clk_en;
        hold_v[F_OTSD] = latch_otsd_en & ~otsd_autorec_en;
        hold_v[F_OTW]  = latch_otw_en;
        hold_v[F_DC]   = 1'b1;
    end

    // Only the warning bit can be masked.
    always_comb begin
        mask_v        = '0;
        mask_v[F_OTW] = otw_mask;
    end

    pfm_fault_bank #(.N(NFLT)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (flt_in),
        .latch_en (hold_v),
        .mask     (mask_v),
        .clr      (fault_clr),
        .flags    (flt_flags)
    );

    assign err_any = |(flt_flags & ERR_BITS);
    assign fault_n = ~(|flt_flags);

    pfm_state_ctrl u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (state_req),
        .err_any (err_any),
        .state   (state_eff)
    );
endmodule

// File: rtl/pfm_checker.sv
// Timing properties of the power-state and fault manager, bound to its top.
// Assumes single-cycle clear pulses and inputs synchronous to clk.
module pfm_checker
    import pfm_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [ST_W-1:0] state_req,
    input logic [NFLT-1:0] flt_in,
    input logic            otw_mask,
    input logic            fault_clr,
    input logic [ST_W-1:0] state_eff,
    input logic [NFLT-1:0] flt_flags,
    input logic            fault_n
);
    AST_REQ_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flt_flags & ERR_BITS)) |=> state_eff == $past(state_req)); // R1
    AST_ERR_FORCES_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flt_flags & ERR_BITS)) |=> state_eff == 2'b10); // R3
    AST_OC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        flt_in[F_OC] |=> flt_flags[F_OC]); // R4
    AST_OC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_in[F_OC] |=> !flt_flags[F_OC]); // R4
    AST_DC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        flt_flags[F_DC] && !fault_clr |=> flt_flags[F_DC]); // R5
    AST_OTW_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        otw_mask |=> !flt_flags[F_OTW]); // R8
    AST_DC_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        flt_in[F_DC] |=> !fault_n); // R10
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr && flt_in[F_DC] |=> flt_flags[F_DC]); // R11
endmodule

bind pwr_fault_mgr pfm_checker u_pfm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_req (state_req),
    .flt_in    (flt_in),
    .otw_mask  (otw_mask),
    .fault_clr (fault_clr),
    .state_eff (state_eff),
    .flt_flags (flt_flags),
    .fault_n   (fault_n)
);

// File: tb/pwr_fault_mgr_test.sv
`timescale 1ns/1ps
module pwr_fault_mgr_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] state_req;
    logic [6:0] flt_in;
    logic       latch_clk_en, latch_otsd_en, latch_otw_en, otw_mask, otsd_autorec_en;
    logic       fault_clr;
    logic [1:0] state_eff;
    logic [6:0] flt_flags;
    logic       fault_n;
    int checks = 0;
    int failures = 0;

    pwr_fault_mgr uut (
        .clk(clk), .rst_n(rst_n), .state_req(state_req), .flt_in(flt_in),
        .latch_clk_en(latch_clk_en), .latch_otsd_en(latch_otsd_en),
        .latch_otw_en(latch_otw_en), .otw_mask(otw_mask),
        .otsd_autorec_en(otsd_autorec_en), .fault_clr(fault_clr),
        .state_eff(state_eff), .flt_flags(flt_flags), .fault_n(fault_n)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0, 1, 2: return "R4";
            3, 5:    return "R6";
            4:       return "R7";
            default: return "R5";
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; state_req = 2'b11; flt_in = '0; fault_clr = 1'b0;
        latch_clk_en = 0; latch_otsd_en = 0; latch_otw_en = 0;
        otw_mask = 0; otsd_autorec_en = 0;
        repeat (3) @(negedge clk);
        chk("R2 state", state_eff, 0);
        chk("R2 flags", flt_flags, 0);
        chk("R2 pin", fault_n, 1);
        rst_n = 1'b1;
        // R1: each request passes through, including deep sleep straight to play.
        for (int s = 0; s < 4; s++) begin
            state_req = 2'(s);
            @(negedge clk);
            chk("R1 pass", state_eff, s);
        end
        state_req = 2'b00; @(negedge clk);
        state_req = 2'b11; @(negedge clk);
        chk("R1 deep to play", state_eff, 3);

        // Sweep: every fault bit, configuration and requested state.
        for (int i = 0; i < 7; i++) begin
            for (int cfg = 0; cfg < 32; cfg++) begin
                for (int s = 0; s < 4; s++) begin
                    bit rep, hold, err;
                    latch_clk_en = cfg[0]; latch_otsd_en = cfg[1];
                    latch_otw_en = cfg[2]; otw_mask = cfg[3];
                    otsd_autorec_en = cfg[4];
                    rep  = !(i == 5 && cfg[3]);
                    hold = (i == 6) || (i == 3 && cfg[0]) ||
                           (i == 4 && cfg[1] && !cfg[4]) || (i == 5 && cfg[2]);
                    err  = (i != 5);
                    state_req = 2'(s);
                    flt_in = 7'(1 << i);
                    @(negedge clk);
                    chk(i == 5 ? "R8 flag" : tag_of(i), flt_flags[i], rep);
                    chk("R10 pin set", fault_n, !rep);
                    flt_in = '0;
                    @(negedge clk);
                    chk(tag_of(i), flt_flags[i], rep && hold);
                    chk(err ? "R3 hiz" : "R9 no hiz", state_eff, (rep && err) ? 2 : s);
                    @(negedge clk);
                    chk(err ? "R3 resume" : "R9 resume", state_eff,
                        (rep && err && hold) ? 2 : s);
                    fault_clr = 1'b1;
                    @(negedge clk);
                    fault_clr = 1'b0;
                    chk("R11 cleared", flt_flags, 0);
                    chk("R10 pin clear", fault_n, 1);
                    @(negedge clk);
                    chk("R3 after clear", state_eff, s);
                end
            end
        end

        // R11: an input still high during the clear keeps its flag set.
        latch_clk_en = 0; latch_otsd_en = 0; latch_otw_en = 0;
        otw_mask = 0; otsd_autorec_en = 0;
        flt_in = 7'b1000000;
        @(negedge clk);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        chk("R11 set wins", flt_flags[6], 1);
        flt_in = '0;
        @(negedge clk);
        chk("R5 still held", flt_flags[6], 1);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        chk("R11 clear after drop", flt_flags[6], 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule